// File: doc/BRIEF.md
# Three-Channel Constant-Weight Hierarchical Decoder

The block takes a 12-bit pattern that arrives on three 4-wire constant-weight channels and rebuilds a 6-bit data word from it. Each channel is meant to carry a word with exactly two ones. The six legal words are grouped into three subsets. Inside a subset the two words are bitwise complements, so they differ in all four bits. Two channels carry data. The third carries a parity subset that equals the sum of the two data subsets, mod 3.

Decoding works in levels. A channel whose weight is not two is marked bad. If exactly one channel is bad, the mod-3 checksum of the two good channels gives back its subset. The bad channel's word is then taken as whichever of the two subset members lies closer in Hamming distance to the received bits. The result is registered. It is presented with a corrected flag or an uncorrectable flag and a valid strobe.

Top module: `cw_hier_decoder`

## Requirements
- R1: Channel 0 is `code_i[11:8]`, channel 1 is `code_i[7:4]` and channel 2 (parity) is `code_i[3:0]`. A channel is bad exactly when its count of ones differs from two.
- R2: Subset 0 holds {0011, 1100}, subset 1 holds {0101, 1010} and subset 2 holds {0110, 1001}. In each subset the word listed first has select 0 and the other has select 1. When all channels are good, the channel 2 subset equals (s0 + s1) mod 3, and 3*s0 + s1 <= 7, the output is `data_o[5:3]` = 3*s0 + s1 and `data_o[2:0]` = {sel0, sel1, sel2}, with both flags clear.
- R3: When exactly one data channel is bad, its subset is rebuilt as (s2 - other) mod 3. Example: channel 0 = 1101, channel 1 = 0101, channel 2 = 0011 gives `data_o` = 6'b111_100.
- R4: When only the parity channel is bad, its subset is rebuilt as (s0 + s1) mod 3, and its select bit comes from the received word.
- R5: A repaired word is the member of the rebuilt subset with the smaller Hamming distance to the received bits. On a tie (received weight 0 or 4) the first-listed member is chosen.
- R6: `corrected_o` is 1 exactly when one channel was bad and the repaired subset pair gives 3*s0 + s1 <= 7.
- R7: Two or three bad channels raise `uncorrectable_o`.
- R8: Three good channels whose subsets break the mod-3 checksum raise `uncorrectable_o`.
- R9: A subset pair s0 = s1 = 2 (value 8) raises `uncorrectable_o`, whether or not a repair took place.
- R10: While `uncorrectable_o` is 1, `data_o` is zero. `corrected_o` and `uncorrectable_o` are never both 1.
- R11: `valid_o` follows `valid_i` one clock later. When `valid_i` is 0, `data_o` and both flags keep their values.
- R12: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pattern strobe |
| code_i | input | 12 | Three 4-bit channel words |
| valid_o | output | 1 | Output strobe, one cycle after valid_i |
| data_o | output | 6 | Recovered data word |
| corrected_o | output | 1 | One channel was repaired |
| uncorrectable_o | output | 1 | Pattern could not be decoded |

## Verification
All 4096 values of `code_i` are applied, and each result is compared with a bench model built from the subset table and the checksum rule. The sweep reaches every combination of good and bad channels. It separates clean words, repairs of a data channel, repairs of the parity channel, weight-0 and weight-4 ties, checksum failures and the out-of-range pair. The worked example with a bad first channel gets its own check. Idle cycles with a changed input show that the outputs hold, and the reset state is checked before the sweep.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int SYM_W  = 4;
  localparam int NUM_CH = 3;
  localparam int SUB_W  = 2;
  localparam int VAL_W  = 4;
  localparam int DATA_W = 3 + NUM_CH;
  localparam int CODE_W = SYM_W * NUM_CH;

  typedef logic [SUB_W-1:0] subset_t;
  typedef logic [SYM_W-1:0] sym_t;

  function automatic subset_t add_mod3(subset_t a, subset_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  function automatic subset_t sub_mod3(subset_t a, subset_t b);
    logic [2:0] s;
    s = {1'b0, a} + 3'd3 - {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  // select-0 member; the select-1 member is its complement
  function automatic sym_t first_member(subset_t k);
    case (k)
      2'd0:    return 4'b0011;
      2'd1:    return 4'b0101;
      default: return 4'b0110;
    endcase
  endfunction
endpackage

// File: rtl/cw_sym_classify.sv
module cw_sym_classify
  import cw_pkg::*;
(
  input  sym_t    sym_i,
  output logic    ok_o,
  output subset_t subset_o,
  output logic    sel_o
);
  always_comb begin
    ok_o     = ($countones(sym_i) == 2);
    subset_o = '0;
    for (int k = 0; k < 3; k++) begin
      if (sym_i == first_member(subset_t'(k)) || sym_i == ~first_member(subset_t'(k)))
        subset_o = subset_t'(k);
    end
    sel_o = ok_o && (sym_i != first_member(subset_o));
  end

  always_comb begin
    if (ok_o) assert_subset_legal_R2: assert (subset_o != 2'd3);
  end
endmodule

// File: rtl/cw_sym_repair.sv
module cw_sym_repair
  import cw_pkg::*;
(
  input  subset_t subset_i,
  input  sym_t    sym_i,
  output logic    sel_o
);
  int dist_first;

  // distance to the complement is SYM_W - dist_first; ties keep select 0
  always_comb begin
    dist_first = $countones(sym_i ^ first_member(subset_i));
    sel_o      = (dist_first > SYM_W / 2);
  end
endmodule

// File: rtl/cw_subset_recover.sv
module cw_subset_recover
  import cw_pkg::*;
(
  input  logic [NUM_CH-1:0] ok_i,
  input  subset_t           sub_i [NUM_CH],
  output subset_t           sub_o [NUM_CH],
  output logic [1:0]        n_bad_o,
  output logic              sum_ok_o
);
  always_comb begin
    n_bad_o  = 2'($countones(~ok_i));
    sum_ok_o = (sub_i[2] == add_mod3(sub_i[0], sub_i[1]));
    sub_o    = sub_i;
    if (n_bad_o == 2'd1) begin
      if (!ok_i[0])      sub_o[0] = sub_mod3(sub_i[2], sub_i[1]);
      else if (!ok_i[1]) sub_o[1] = sub_mod3(sub_i[2], sub_i[0]);
      else               sub_o[2] = add_mod3(sub_i[0], sub_i[1]);
    end
  end

  always_comb begin
    if (n_bad_o == 2'd1)
      assert_rebuilt_sum_R3: assert (sub_o[2] == add_mod3(sub_o[0], sub_o[1]));
  end
endmodule

// File: rtl/cw_hier_decoder.sv
module cw_hier_decoder
  import cw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              corrected_o,
  output logic              uncorrectable_o
);
  logic [NUM_CH-1:0] ok, sel_rx, sel_fix;
  subset_t           sub_rx  [NUM_CH];
  subset_t           sub_rec [NUM_CH];
  logic [1:0]        n_bad;
  logic              sum_ok;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sym_t sym;
    assign sym = code_i[SYM_W*(NUM_CH-c)-1 -: SYM_W];

    cw_sym_classify u_cls (
      .sym_i(sym), .ok_o(ok[c]), .subset_o(sub_rx[c]), .sel_o(sel_rx[c])
    );
    cw_sym_repair u_rep (
      .subset_i(sub_rec[c]), .sym_i(sym), .sel_o(sel_fix[c])
    );
  end

  cw_subset_recover u_rec (
    .ok_i(ok), .sub_i(sub_rx), .sub_o(sub_rec), .n_bad_o(n_bad), .sum_ok_o(sum_ok)
  );

  logic [VAL_W-1:0]  val;
  logic [DATA_W-1:0] data_d;
  logic              corr_d, unc_d;

  always_comb begin
    val    = 4'(sub_rec[0]) * 4'd3 + 4'(sub_rec[1]);
    unc_d  = (n_bad >= 2'd2) || (n_bad == 2'd0 && !sum_ok) || (val > 4'd7);
    corr_d = (n_bad == 2'd1) && !unc_d;
    data_d = '0;
    if (!unc_d) begin
      data_d[DATA_W-1 -: 3] = val[2:0];
      for (int c = 0; c < NUM_CH; c++)
        data_d[NUM_CH-1-c] = ok[c] ? sel_rx[c] : sel_fix[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o         <= 1'b0;
      data_o          <= '0;
      corrected_o     <= 1'b0;
      uncorrectable_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o          <= data_d;
        corrected_o     <= corr_d;
        uncorrectable_o <= unc_d;
      end
    end
  end

  assert_valid_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(corrected_o) && $stable(uncorrectable_o)));
  assert_flags_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({corrected_o, uncorrectable_o}));
  assert_unc_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorrectable_o |-> (data_o == '0));
  assert_multi_bad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && n_bad >= 2'd2) |=> uncorrectable_o);
endmodule

// File: tb/cw_hier_decoder_tb_top.sv
`timescale 1ns/1ps
module cw_hier_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] code_i = '0;
  logic        valid_o, corrected_o, uncorrectable_o;
  logic [5:0]  data_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #10 clk_i = ~clk_i;

  cw_hier_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .code_i(code_i),
    .valid_o(valid_o), .data_o(data_o), .corrected_o(corrected_o),
    .uncorrectable_o(uncorrectable_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] member(int k, int s);
    logic [3:0] f;
    f = (k == 0) ? 4'b0011 : (k == 1) ? 4'b0101 : 4'b0110;
    return s ? ~f : f;
  endfunction

  // returns {corr, unc, data[5:0]} and a category tag
  function automatic logic [7:0] model(input logic [11:0] x, output string tag);
    int sub[3], sel[3], good[3], nbad, bad, v;
    logic [3:0] w[3];
    logic [5:0] d;
    nbad = 0; bad = 0;
    for (int c = 0; c < 3; c++) begin
      w[c] = x[11-4*c -: 4];
      good[c] = ($countones(w[c]) == 2);
      sub[c] = 0; sel[c] = 0;
      for (int k = 0; k < 3; k++)
        for (int s = 0; s < 2; s++)
          if (w[c] == member(k, s)) begin sub[c] = k; sel[c] = s; end
      if (!good[c]) begin nbad++; bad = c; end
    end
    if (nbad >= 2) begin tag = "R7"; return 8'b01_000000; end
    if (nbad == 0 && sub[2] != (sub[0] + sub[1]) % 3) begin tag = "R8"; return 8'b01_000000; end
    if (nbad == 1) begin
      int d0, d1;
      if (bad == 0)      sub[0] = (sub[2] - sub[1] + 3) % 3;
      else if (bad == 1) sub[1] = (sub[2] - sub[0] + 3) % 3;
      else               sub[2] = (sub[0] + sub[1]) % 3;
      d0 = $countones(w[bad] ^ member(sub[bad], 0));
      d1 = $countones(w[bad] ^ member(sub[bad], 1));
      sel[bad] = (d1 < d0) ? 1 : 0;   // R5 tie keeps first member
      tag = (bad == 2) ? "R4/R5" : "R3/R5";
    end else tag = "R2";
    v = 3 * sub[0] + sub[1];
    if (v > 7) begin tag = "R9"; return 8'b01_000000; end
    d = {v[2:0], sel[0][0], sel[1][0], sel[2][0]};
    return {(nbad == 1), 1'b0, d};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] e;
    string tag;
    logic [5:0] held;
    // R12 reset state
    #35;
    check({valid_o, data_o, corrected_o, uncorrectable_o} == 9'd0, "R12 reset",
          {valid_o, data_o, corrected_o, uncorrectable_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1..R10 exhaustive sweep
    for (int i = 0; i < 4096; i++) begin
      code_i  = 12'(i);
      valid_i = 1'b1;
      e = model(12'(i), tag);
      @(negedge clk_i);
      check(valid_o == 1'b1, "R11 valid", valid_o, 1);
      check(data_o == e[5:0], $sformatf("%s/R1 data code=%03h", tag, i), data_o, e[5:0]);
      check(corrected_o == e[7], $sformatf("R6 corrected code=%03h", i), corrected_o, e[7]);
      check(uncorrectable_o == e[6], $sformatf("%s/R10 uncorrectable code=%03h", tag, i),
            uncorrectable_o, e[6]);
    end

    // R3 worked example: 1101 / 0101 / 0011
    code_i = 12'b1101_0101_0011;
    @(negedge clk_i);
    check(data_o == 6'b111_100 && corrected_o, "R3 example", {corrected_o, data_o}, 7'b1_111100);

    // R11 hold while idle
    held = data_o;
    valid_i = 1'b0;
    code_i = 12'b1111_1111_1111;
    @(negedge clk_i);
    check(valid_o == 1'b0, "R11 idle valid", valid_o, 0);
    check(data_o == held && corrected_o && !uncorrectable_o, "R11 hold",
          {corrected_o, uncorrectable_o, data_o}, {2'b10, held});
    @(negedge clk_i);
    check(data_o == held, "R11 hold 2", data_o, held);

    finish_run();
  end
endmodule